// File: doc/BRIEF.md
# CRT Timing Generator

This block produces the raster timing for a cathode-ray or VGA-style display. Software loads a small set of registers through a plain write port. The horizontal quantities are counted in character clocks, where one character is eight pixels. The vertical quantities are counted in lines. Each clock is one character. From these registers the block derives a display-enable strobe, horizontal and vertical sync pulses with selectable polarity, and a byte address into the frame buffer for the character being shown.

Timing words are staged in a shadow copy. While the raster runs, a staged word reaches the working copy only at the wrap from the last character of the last line to the first character of the next frame. While the raster is stopped, staged words reach the working copy at once. Clearing either of the two run bits in the control word parks the raster, so software can reprogram a mode safely and then restart from the top-left corner.

The frame-buffer address is the base address plus the line pitch times the line number, plus the character offset within the line. Both terms are scaled by the bytes per pixel that the pixel-format code selects.

Top module: `crt_timing_gen`

## Requirements
- R1: The horizontal count runs from 0 to the line-total field (word 0, bits 8:0, holding characters − 1) and then returns to 0, so each line lasts line-total + 1 clocks.
- R2: The line count advances by one at each horizontal wrap and returns to 0 after the frame-total field (word 2, bits 10:0, holding lines − 1).
- R3: Display enable is high exactly when the horizontal count ≤ the visible-characters field (word 0, bits 24:16) and the line count ≤ the visible-lines field (word 2, bits 26:16). All outputs are registered, so a raster position appears on the pins one clock after the counters hold it.
- R4: The horizontal sync is active for counts c with start ≤ c < start + width. The start is 9 bits, split between word 1 bits 7:0 (low part) and word 1 bit 12 (bit 8). The width is 6 bits at word 1 bits 21:16. A width of 0 gives no pulse.
- R5: The vertical sync is active for lines l with start ≤ l < start + width. The start is at word 3 bits 10:0 and the width is 5 bits at word 3 bits 20:16.
- R6: Control word 6 bit 2 makes the horizontal sync active low, and bit 3 does the same for the vertical sync. When a bit is clear, that sync is active high.
- R7: While display enable is high, the fetch address is (base with bits 2:0 forced to 0) + line × pitch × 8 × B + count × 8 × B, modulo 2^20. The base is word 4 bits 19:0 and the pitch is word 5 bits 9:0. B is 1, 2, 2 or 4 for format codes 0, 1, 2, 3 in word 6 bits 9:8. While display enable is low, the fetch address is 0.
- R8: The raster runs only when control bits 0 and 1 are both set. If either is clear, the counters sit at 0, display enable is low and both syncs rest at their inactive level. Setting both bits restarts the raster at position (0,0), and that position reaches the outputs one clock after the enabling write.
- R9: While the raster runs, writes to words 0–5 and to the polarity and format bits take effect at the next frame start. This includes a write that lands in the last clock of a frame. A write one clock later waits a whole further frame.
- R10: After reset the raster is stopped and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word index (0–6) |
| wr_data | input | DW | Register write data |
| de_o | output | 1 | Display enable |
| hsync_o | output | 1 | Horizontal sync, polarity per R6 |
| vsync_o | output | 1 | Vertical sync, polarity per R6 |
| fetch_addr_o | output | AW | Frame-buffer byte address |

## Verification
A software write and the frame-start reload can fall in the same clock. The bench provokes this by issuing a visible-width write exactly in the last clock of a frame, and again one clock later. It judges the result by comparing every output against a model that applies the new setting from the next frame in the first case and from the frame after that in the second. A further test writes mid-frame and checks that the running frame is untouched.

// File: rtl/crt_pkg.sv
package crt_pkg;

  typedef enum logic [2:0] {
    REG_HTIME = 3'd0,
    REG_HSYNC = 3'd1,
    REG_VTIME = 3'd2,
    REG_VSYNC = 3'd3,
    REG_BASE  = 3'd4,
    REG_PITCH = 3'd5,
    REG_CTRL  = 3'd6
  } reg_idx_e;

  typedef enum logic [1:0] {
    PIX_8  = 2'd0,
    PIX_15 = 2'd1,
    PIX_16 = 2'd2,
    PIX_32 = 2'd3
  } pix_code_e;

  localparam int UPPER_LSB   = 16;
  localparam int HS_TOP_POS  = 12;
  localparam int HSW_BITS    = 6;
  localparam int VSW_BITS    = 5;
  localparam int CTL_RUN_A   = 0;
  localparam int CTL_RUN_B   = 1;
  localparam int CTL_HNEG    = 2;
  localparam int CTL_VNEG    = 3;
  localparam int CTL_PIX_LSB = 8;

  // log2 of bytes per 8-pixel character for a format code
  function automatic logic [2:0] char_shift(input logic [1:0] code);
    case (code)
      PIX_8:   char_shift = 3'd3;
      PIX_15:  char_shift = 3'd4;
      PIX_16:  char_shift = 3'd4;
      default: char_shift = 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/crt_regs.sv
module crt_regs
  import crt_pkg::*;
#(
  parameter int HW = 9,
  parameter int VW = 11,
  parameter int AW = 20,
  parameter int PW = 10,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                load,
  output logic                run,
  output logic [HW-1:0]       htot,
  output logic [HW-1:0]       hdisp,
  output logic [HW-1:0]       hss,
  output logic [HSW_BITS-1:0] hsw,
  output logic [VW-1:0]       vtot,
  output logic [VW-1:0]       vdisp,
  output logic [VW-1:0]       vss,
  output logic [VSW_BITS-1:0] vsw,
  output logic [AW-1:0]       base,
  output logic [PW-1:0]       pitch,
  output logic                hneg,
  output logic                vneg,
  output logic [1:0]          pix
);

  typedef struct packed {
    logic [HW-1:0]       htot;
    logic [HW-1:0]       hdisp;
    logic [HW-1:0]       hss;
    logic [HSW_BITS-1:0] hsw;
    logic [VW-1:0]       vtot;
    logic [VW-1:0]       vdisp;
    logic [VW-1:0]       vss;
    logic [VSW_BITS-1:0] vsw;
    logic [AW-1:0]       base;
    logic [PW-1:0]       pitch;
    logic                hneg;
    logic                vneg;
    logic [1:0]          pix;
  } tset_t;

  tset_t      shd_q, shd_d, act_q;
  logic [1:0] en_q, en_d;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  // staged copy with the current write merged in
  always_comb begin
    shd_d = shd_q;
    en_d  = en_q;
    if (wr_en) begin
      case (wr_addr)
        REG_HTIME: begin
          shd_d.htot  = wr_data[HW-1:0];
          shd_d.hdisp = wr_data[UPPER_LSB +: HW];
        end
        REG_HSYNC: begin
          shd_d.hss = HW'({wr_data[HS_TOP_POS], wr_data[7:0]});
          shd_d.hsw = wr_data[UPPER_LSB +: HSW_BITS];
        end
        REG_VTIME: begin
          shd_d.vtot  = wr_data[VW-1:0];
          shd_d.vdisp = wr_data[UPPER_LSB +: VW];
        end
        REG_VSYNC: begin
          shd_d.vss = wr_data[VW-1:0];
          shd_d.vsw = wr_data[UPPER_LSB +: VSW_BITS];
        end
        REG_BASE:  shd_d.base  = {wr_data[AW-1:3], 3'b000};
        REG_PITCH: shd_d.pitch = wr_data[PW-1:0];
        REG_CTRL: begin
          en_d       = {wr_data[CTL_RUN_B], wr_data[CTL_RUN_A]};
          shd_d.hneg = wr_data[CTL_HNEG];
          shd_d.vneg = wr_data[CTL_VNEG];
          shd_d.pix  = wr_data[CTL_PIX_LSB +: 2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q <= '0;
      act_q <= '0;
      en_q  <= '0;
    end else begin
      shd_q <= shd_d;
      en_q  <= en_d;
      if (load) act_q <= shd_d;
    end
  end

  assign run   = &en_q;
  assign htot  = act_q.htot;
  assign hdisp = act_q.hdisp;
  assign hss   = act_q.hss;
  assign hsw   = act_q.hsw;
  assign vtot  = act_q.vtot;
  assign vdisp = act_q.vdisp;
  assign vss   = act_q.vss;
  assign vsw   = act_q.vsw;
  assign base  = act_q.base;
  assign pitch = act_q.pitch;
  assign hneg  = act_q.hneg;
  assign vneg  = act_q.vneg;
  assign pix   = act_q.pix;

endmodule

// File: rtl/crt_raster.sv
module crt_raster #(
  parameter int HW = 9,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] htot,
  input  logic [VW-1:0] vtot,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          line_end,
  output logic          frame_end
);

  assign line_end  = run && (h_cnt == htot);
  assign frame_end = line_end && (v_cnt == vtot);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (line_end) begin
      h_cnt <= '0;
      v_cnt <= (v_cnt == vtot) ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/crt_sync_win.sv
module crt_sync_win #(
  parameter int CW = 9,
  parameter int WW = 6
) (
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] start,
  input  logic [WW-1:0] width,
  output logic          active
);

  localparam int EW = ((CW > WW) ? CW : WW) + 1;

  logic [EW-1:0] pos_x, start_x, stop_x;

  assign pos_x   = EW'(pos);
  assign start_x = EW'(start);
  assign stop_x  = start_x + EW'(width);
  assign active  = (pos_x >= start_x) && (pos_x < stop_x);

endmodule

// File: rtl/crt_fetch_addr.sv
module crt_fetch_addr
  import crt_pkg::*;
#(
  parameter int HW = 9,
  parameter int AW = 20,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          line_end,
  input  logic [HW-1:0] h_cnt,
  input  logic [AW-1:0] base,
  input  logic [PW-1:0] pitch,
  input  logic [1:0]    pix,
  output logic [AW-1:0] addr
);

  logic [2:0]    shift;
  logic [AW-1:0] stride, char_off, line_off;

  assign shift    = char_shift(pix);
  assign stride   = AW'(pitch) << shift;
  assign char_off = AW'(h_cnt) << shift;
  assign addr     = base + line_off + char_off;

  // running offset of the current line from the frame base
  always_ff @(posedge clk) begin
    if (rst || load)   line_off <= '0;
    else if (line_end) line_off <= line_off + stride;
  end

endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_pkg::*;
#(
  parameter int HW = 9,
  parameter int VW = 11,
  parameter int AW = 20,
  parameter int PW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic [AW-1:0] fetch_addr_o
);

  logic                run, load, line_end, frame_end;
  logic [HW-1:0]       htot_a, hdisp_a, hss_a, h_cnt;
  logic [HSW_BITS-1:0] hsw_a;
  logic [VW-1:0]       vtot_a, vdisp_a, vss_a, v_cnt;
  logic [VSW_BITS-1:0] vsw_a;
  logic [AW-1:0]       base_a, addr_c;
  logic [PW-1:0]       pitch_a;
  logic                hneg_a, vneg_a;
  logic [1:0]          pix_a;
  logic                de_c, hact, vact;

  assign load = !run || frame_end;

  crt_regs #(.HW(HW), .VW(VW), .AW(AW), .PW(PW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .run(run),
    .htot(htot_a), .hdisp(hdisp_a), .hss(hss_a), .hsw(hsw_a),
    .vtot(vtot_a), .vdisp(vdisp_a), .vss(vss_a), .vsw(vsw_a),
    .base(base_a), .pitch(pitch_a), .hneg(hneg_a), .vneg(vneg_a), .pix(pix_a)
  );

  crt_raster #(.HW(HW), .VW(VW)) u_raster (
    .clk(clk), .rst(rst), .run(run), .htot(htot_a), .vtot(vtot_a),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .line_end(line_end), .frame_end(frame_end)
  );

  crt_sync_win #(.CW(HW), .WW(HSW_BITS)) u_hwin (
    .pos(h_cnt), .start(hss_a), .width(hsw_a), .active(hact)
  );

  crt_sync_win #(.CW(VW), .WW(VSW_BITS)) u_vwin (
    .pos(v_cnt), .start(vss_a), .width(vsw_a), .active(vact)
  );

  crt_fetch_addr #(.HW(HW), .AW(AW), .PW(PW)) u_addr (
    .clk(clk), .rst(rst), .load(load), .line_end(line_end), .h_cnt(h_cnt),
    .base(base_a), .pitch(pitch_a), .pix(pix_a), .addr(addr_c)
  );

  assign de_c = (h_cnt <= hdisp_a) && (v_cnt <= vdisp_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o         <= 1'b0;
      hsync_o      <= 1'b0;
      vsync_o      <= 1'b0;
      fetch_addr_o <= '0;
    end else if (!run) begin
      de_o         <= 1'b0;
      hsync_o      <= hneg_a;
      vsync_o      <= vneg_a;
      fetch_addr_o <= '0;
    end else begin
      de_o         <= de_c;
      hsync_o      <= hact ^ hneg_a;
      vsync_o      <= vact ^ vneg_a;
      fetch_addr_o <= de_c ? addr_c : '0;
    end
  end

endmodule

// File: rtl/crt_timing_chk.sv
module crt_timing_chk
  import crt_pkg::*;
#(
  parameter int HW = 9,
  parameter int VW = 11,
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic          run,
  input logic          line_end,
  input logic          frame_end,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic [HW-1:0] htot_a,
  input logic [VW-1:0] vtot_a,
  input logic          hneg_a,
  input logic          de_o,
  input logic          hsync_o,
  input logic [AW-1:0] fetch_addr_o
);

  logic ctl_wr;
  assign ctl_wr = wr_en && (wr_addr == REG_CTRL);

  p_h_bound_r1: assert property (@(posedge clk) disable iff (rst)
    run |-> (h_cnt <= htot_a));

  p_v_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !line_end && !ctl_wr) |=> $stable(v_cnt));

  p_v_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run && line_end && !frame_end && !ctl_wr) |=> (v_cnt == $past(v_cnt) + 1'b1));

  p_addr_align_r7: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (fetch_addr_o[2:0] == 3'b000));

  p_addr_blank_r7: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (fetch_addr_o == '0));

  p_idle_de_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !de_o);

  p_idle_sync_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (hsync_o == $past(hneg_a)));

  p_hold_mid_frame_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !frame_end) |=> ($stable(htot_a) && $stable(vtot_a)));

endmodule

bind crt_timing_gen crt_timing_chk #(.HW(HW), .VW(VW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .run(run),
  .line_end(line_end), .frame_end(frame_end), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .htot_a(htot_a), .vtot_a(vtot_a), .hneg_a(hneg_a), .de_o(de_o),
  .hsync_o(hsync_o), .fetch_addr_o(fetch_addr_o)
);

// File: tb/sim_crt_timing_gen.sv
`timescale 1ns/100ps
module sim_crt_timing_gen;

  typedef struct packed {
    logic [8:0]  htot;
    logic [8:0]  hdisp;
    logic [8:0]  hss;
    logic [5:0]  hsw;
    logic [10:0] vtot;
    logic [10:0] vdisp;
    logic [10:0] vss;
    logic [4:0]  vsw;
    logic [19:0] base;
    logic [9:0]  pitch;
    logic [1:0]  pix;
    logic        hneg;
    logic        vneg;
  } cfg_t;

  localparam int NVEC = 4;
  localparam cfg_t VEC [NVEC] = '{
    '{9'd9,   9'd6,   9'd7,   6'd2,  11'd5, 11'd3, 11'd4, 5'd1,  20'h00100, 10'd7,  2'd0, 1'b0, 1'b0},
    '{9'd15,  9'd11,  9'd12,  6'd0,  11'd3, 11'd2, 11'd0, 5'd2,  20'hFFF0F, 10'd16, 2'd3, 1'b1, 1'b1},
    '{9'd300, 9'd255, 9'd260, 6'd63, 11'd1, 11'd0, 11'd1, 5'd31, 20'h00040, 10'd40, 2'd1, 1'b0, 1'b1},
    '{9'd4,   9'd4,   9'd0,   6'd5,  11'd2, 11'd2, 11'd2, 5'd1,  20'h00008, 10'd5,  2'd2, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        de_o, hsync_o, vsync_o;
  logic [19:0] fetch_addr_o;

  int nchk = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  crt_timing_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .fetch_addr_o(fetch_addr_o)
  );

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  function automatic int frame_len(input cfg_t c);
    return (int'(c.htot) + 1) * (int'(c.vtot) + 1);
  endfunction

  // expected {de, hsync, vsync, addr} at raster position k
  function automatic logic [22:0] model(input cfg_t c, input int k);
    int hl, p, h, v, bpp, a;
    logic de, hs, vs;
    logic [19:0] ad;
    hl  = int'(c.htot) + 1;
    p   = k % frame_len(c);
    h   = p % hl;
    v   = p / hl;
    de  = (h <= int'(c.hdisp)) && (v <= int'(c.vdisp));
    hs  = ((h >= int'(c.hss)) && (h < int'(c.hss) + int'(c.hsw))) ^ c.hneg;
    vs  = ((v >= int'(c.vss)) && (v < int'(c.vss) + int'(c.vsw))) ^ c.vneg;
    bpp = (c.pix == 2'd0) ? 1 : ((c.pix == 2'd3) ? 4 : 2);
    a   = (int'(c.base) & ~7) + v * int'(c.pitch) * 8 * bpp + h * 8 * bpp;
    ad  = de ? a[19:0] : 20'h0;
    return {de, hs, vs, ad};
  endfunction

  function automatic logic [31:0] word(input cfg_t c, input int idx, input logic [1:0] en);
    logic [31:0] w;
    w = '0;
    case (idx)
      0: begin w[8:0] = c.htot; w[24:16] = c.hdisp; end
      1: begin w[7:0] = c.hss[7:0]; w[12] = c.hss[8]; w[21:16] = c.hsw; end
      2: begin w[10:0] = c.vtot; w[26:16] = c.vdisp; end
      3: begin w[10:0] = c.vss; w[20:16] = c.vsw; end
      4: w[19:0] = c.base;
      5: w[9:0] = c.pitch;
      default: begin w[1:0] = en; w[2] = c.hneg; w[3] = c.vneg; w[9:8] = c.pix; end
    endcase
    return w;
  endfunction

  task automatic chk(input logic [22:0] got, input logic [22:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual de/hs/vs/addr=%b/%b/%b/%h expected=%b/%b/%b/%h",
               tag, got[22], got[21], got[20], got[19:0], exp[22], exp[21], exp[20], exp[19:0]);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // stop, load every word, restart
  task automatic prog(input cfg_t c);
    wr(3'd6, word(c, 6, 2'b00));
    for (int i = 0; i < 6; i++) wr(3'(i), word(c, i, 2'b00));
    wr(3'd6, word(c, 6, 2'b11));
  endtask

  // sample n positions; a governs the first frame, b after it; optional write at sample wi
  task automatic watch(input cfg_t a, input cfg_t b, input int n, input int wi,
                       input logic [2:0] wa, input logic [31:0] wd, input string tag);
    int na;
    logic [22:0] exp;
    na = frame_len(a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == wi + 1) wr_en = 1'b0;
      exp = (i < na) ? model(a, i) : model(b, i - na);
      chk({de_o, hsync_o, vsync_o, fetch_addr_o}, exp, tag);
      if (i == wi) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
    end
  endtask

  initial begin
    cfg_t nb;
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({de_o, hsync_o, vsync_o, fetch_addr_o}, 23'h0, "R10 reset");
    repeat (4) @(negedge clk);
    chk({de_o, hsync_o, vsync_o, fetch_addr_o}, 23'h0, "R10 idle after reset");

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int t = 0; t < NVEC; t++) begin
      prog(VEC[t]);
      watch(VEC[t], VEC[t], 2 * frame_len(VEC[t]), -1, 3'd0, 32'h0, "R1 R2 R3 R4 R5 R6 R7 table");
    end

    // R9: mid-frame write leaves current frame alone
    nb = VEC[0];
    nb.hdisp = 9'd3;
    prog(VEC[0]);
    watch(VEC[0], nb, 120, 5, 3'd0, word(nb, 0, 2'b00), "R9 mid-frame write");

    // R9: write in the last clock of a frame applies from the next frame
    prog(VEC[0]);
    watch(VEC[0], nb, 120, 58, 3'd0, word(nb, 0, 2'b00), "R9 write at frame end");

    // R9: write one clock later waits a further frame
    prog(VEC[0]);
    watch(VEC[0], VEC[0], 120, 59, 3'd0, word(nb, 0, 2'b00), "R9 write after frame end");
    watch(nb, nb, 60, -1, 3'd0, 32'h0, "R9 late write applied");

    // R8: clearing one run bit parks the raster at inactive sync levels
    prog(VEC[1]);
    watch(VEC[1], VEC[1], 20, -1, 3'd0, 32'h0, "R8 before stop");
    wr(3'd6, word(VEC[1], 6, 2'b01));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk({de_o, hsync_o, vsync_o, fetch_addr_o}, {1'b0, 1'b1, 1'b1, 20'h0}, "R8 stopped bit1 clear");
    end
    wr(3'd6, word(VEC[1], 6, 2'b11));
    watch(VEC[1], VEC[1], 64, -1, 3'd0, 32'h0, "R8 restart at origin");
    wr(3'd6, word(VEC[1], 6, 2'b10));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk({de_o, hsync_o, vsync_o, fetch_addr_o}, {1'b0, 1'b1, 1'b1, 20'h0}, "R8 stopped bit0 clear");
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule